// File: doc/BRIEF.md
# Serial I/Q Frame-Sync Output Port

This block sends one complex sample per frame over a single serial data line. The frame holds the in-phase word and then the quadrature word, each sent most significant bit first. Each frame is announced by a frame-sync pulse. The data line has its own output enable, so it can be tri-stated whenever the port is not sending. Several ports can then share one receive pin.

The role is chosen by `master_i`:

- **Slave role:** an external device drives the serial clock and the frame sync. Both are brought into the system clock domain through two-flop synchronizers and edge detection. The system clock must run at least four times faster than the serial clock.
- **Master role:** the port makes the serial clock itself by dividing the system clock by an even parameter. It issues a one-period frame sync whenever a new sample pair is waiting.

Sample pairs arrive with a valid strobe. They are held in a one-deep register until a frame starts. A word-length control selects 16-bit or 24-bit words.

Top module: `iq_serial_port`

## Requirements
- R1: A frame carries the I word and then the Q word, each MSB first, so the last bit sent is the Q LSB. In 24-bit mode the full inputs are sent. In 16-bit mode bits [15:0] of each input are sent.
- R2: `sdo_o` and `sdo_oe_o` change only on serial clock rising edges. `sdo_oe_o` rises on the edge that presents the I MSB and falls on the rising edge after the Q LSB. `sdo_o` is 0 while `sdo_oe_o` is low.
- R3: `wlen24_i` is taken at frame start. A value of 0 gives 32 bits per frame, and a value of 1 gives 48 bits per frame.
- R4: In slave mode (`master_i`=0), the frame sync is sampled on each falling edge of `sclk_i`. A high sample starts a frame on the next rising edge. Without a frame sync, `sdo_oe_o` stays low. `sclk_o`, `fsync_o` and `ctl_oe_o` are low in this mode.
- R5: In master mode, `ctl_oe_o` is high. `sclk_o` is the system clock divided by CLK_DIV, with equal high and low phases.
- R6: In master mode, the frame-sync pulse works as follows:
  - `fsync_o` goes high on a rising edge when a pair is pending and the port is idle.
  - It stays high for exactly one serial period.
  - It falls on the rising edge that presents the I MSB.
- R7: In master mode, exactly one frame is sent per latched pair. No frame sync appears while nothing is pending.
- R8: A pair that arrives during a frame is held for the next frame, and a newer pair overwrites it. A pair that arrives in the very cycle a frame starts goes to the next frame.
- R9: In slave mode, a frame sync sampled during a frame is ignored, except in the final bit period. There it starts the next frame back to back on the following rising edge. Each slave frame sends the most recent pair, repeating it if no new pair has arrived.
- R10: After reset, `sdo_o`, `sdo_oe_o`, `sclk_o` and `fsync_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| master_i | input | 1 | 1 = master role, 0 = slave role |
| wlen24_i | input | 1 | 1 = 24-bit words, 0 = 16-bit words |
| smp_valid_i | input | 1 | Sample pair strobe |
| smp_i_i | input | WMAX | In-phase word |
| smp_q_i | input | WMAX | Quadrature word |
| sclk_i | input | 1 | External serial clock (slave role) |
| fsync_i | input | 1 | External frame sync (slave role) |
| sclk_o | output | 1 | Generated serial clock (master role) |
| fsync_o | output | 1 | Generated frame sync (master role) |
| ctl_oe_o | output | 1 | Drive enable for serial clock and frame sync pads |
| sdo_o | output | 1 | Serial data |
| sdo_oe_o | output | 1 | Drive enable for serial data |

## Verification
Two events can coincide:

- **Frame start and a new sample strobe.** The bench places a sample strobe on the exact system cycle on which a slave frame starts. It does this by timing the strobe against the synchronizer delay of the external clock. The check passes if the running frame carries the previously held pair and the following frame carries the new one.
- **Frame sync and the last data bit.** A frame sync is also raised during the last bit period of a frame. The check passes if the next frame begins on the very next rising edge with no idle period, while a frame sync raised mid-frame leaves the data untouched.

// File: rtl/iq_serial_port.sv
module iq_serial_port #(
  parameter int WMAX    = 24,
  parameter int WSHORT  = 16,
  parameter int CLK_DIV = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            master_i,
  input  logic            wlen24_i,
  input  logic            smp_valid_i,
  input  logic [WMAX-1:0] smp_i_i,
  input  logic [WMAX-1:0] smp_q_i,
  input  logic            sclk_i,
  input  logic            fsync_i,
  output logic            sclk_o,
  output logic            fsync_o,
  output logic            ctl_oe_o,
  output logic            sdo_o,
  output logic            sdo_oe_o
);
  localparam int FMAX = 2 * WMAX;
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BW   = $clog2(FMAX);
  localparam logic [BW-1:0] LAST_LONG  = BW'(FMAX - 1);
  localparam logic [BW-1:0] LAST_SHORT = BW'(2 * WSHORT - 1);

  logic [2:0]      sc_sync;
  logic [1:0]      fs_sync;
  logic [CW-1:0]   div_cnt;
  logic            sclk_r, fsync_r;
  logic [WMAX-1:0] hold_i, hold_q;
  logic            pend_v, armed, busy;
  logic [BW-1:0]   bitcnt, last_idx;
  logic [FMAX-1:0] shreg, load;

  wire div_wrap = (div_cnt == CW'(HALF - 1));
  wire rise     = master_i ? (div_wrap & ~sclk_r) : (sc_sync[1] & ~sc_sync[2]);
  wire fall     = master_i ? (div_wrap &  sclk_r) : (~sc_sync[1] & sc_sync[2]);
  wire fs_seen  = master_i ? fsync_r : fs_sync[1];
  wire last_bit = busy && (bitcnt == last_idx);

  assign load = wlen24_i ? {hold_i, hold_q}
                         : {hold_i[WSHORT-1:0], hold_q[WSHORT-1:0], {(FMAX-2*WSHORT){1'b0}}};

  assign ctl_oe_o = master_i;
  assign sclk_o   = master_i & sclk_r;
  assign fsync_o  = master_i & fsync_r;
  assign sdo_oe_o = busy;
  assign sdo_o    = busy & shreg[FMAX-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_sync <= '0;
      fs_sync <= '0;
    end else begin
      sc_sync <= {sc_sync[1:0], sclk_i};
      fs_sync <= {fs_sync[0], fsync_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      sclk_r  <= 1'b0;
    end else if (!master_i) begin
      div_cnt <= '0;
      sclk_r  <= 1'b0;
    end else if (div_wrap) begin
      div_cnt <= '0;
      sclk_r  <= ~sclk_r;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_i <= '0;
      hold_q <= '0;
      pend_v <= 1'b0;
    end else if (smp_valid_i) begin
      hold_i <= smp_i_i;
      hold_q <= smp_q_i;
      pend_v <= 1'b1;
    end else if (rise && armed) begin
      pend_v <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      fsync_r  <= 1'b0;
      busy     <= 1'b0;
      bitcnt   <= '0;
      last_idx <= LAST_SHORT;
      shreg    <= '0;
    end else begin
      if (fall && fs_seen && (!busy || last_bit)) armed <= 1'b1;
      else if (rise)                              armed <= 1'b0;

      if (rise && master_i) begin
        if (fsync_r)                         fsync_r <= 1'b0;
        else if (pend_v && !busy && !armed)  fsync_r <= 1'b1;
      end else if (!master_i) begin
        fsync_r <= 1'b0;
      end

      if (rise) begin
        if (armed) begin
          shreg    <= load;
          busy     <= 1'b1;
          bitcnt   <= '0;
          last_idx <= wlen24_i ? LAST_LONG : LAST_SHORT;
        end else if (last_bit) begin
          busy <= 1'b0;
        end else if (busy) begin
          shreg  <= shreg << 1;
          bitcnt <= bitcnt + 1'b1;
        end
      end
    end
  end

  // R2: data line and its enable move only on serial rising edges
  p_edge_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> ($stable(sdo_o) && $stable(sdo_oe_o)));

  // R3: a frame ends only after its last indexed bit
  p_frame_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdo_oe_o) |-> ($past(bitcnt) == $past(last_idx)));

  // R4: slave stays silent unless a frame sync was taken
  p_slave_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_i && !armed) |=> !$rose(sdo_oe_o));

  // R6: master frame sync ends exactly as the first bit is driven
  p_fsync_first_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (master_i && $fell(fsync_r)) |-> $rose(sdo_oe_o));
endmodule

// File: tb/iq_serial_port_tb.sv
module iq_serial_port_tb;
  localparam int WMAX = 24;
  localparam int DIV  = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic master = 1'b0, w24 = 1'b0, vld = 1'b0, sclk = 1'b0, fs = 1'b0;
  logic [WMAX-1:0] di = '0, dq = '0;
  logic sclk_o, fsync_o, ctl_oe, sdo, sdo_oe;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  iq_serial_port #(.WMAX(WMAX), .WSHORT(16), .CLK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .master_i(master), .wlen24_i(w24),
    .smp_valid_i(vld), .smp_i_i(di), .smp_q_i(dq), .sclk_i(sclk), .fsync_i(fs),
    .sclk_o(sclk_o), .fsync_o(fsync_o), .ctl_oe_o(ctl_oe), .sdo_o(sdo), .sdo_oe_o(sdo_oe));

  task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] expf(input logic [23:0] i, input logic [23:0] q, input bit l);
    return l ? {i, q} : {i[15:0], q[15:0], 16'h0};
  endfunction

  function automatic logic [47:0] msk(input logic [47:0] v, input bit l);
    return l ? v : {v[47:16], 16'h0};
  endfunction

  task automatic push(input logic [23:0] i, input logic [23:0] q);
    di = i; dq = q; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
  endtask

  task automatic tick(input bit f, input bit inj, input logic [23:0] ii, input logic [23:0] qq,
                      output bit t_oe, output bit t_sdo, output bit t_fs);
    if (master) begin
      while (sclk_o !== 1'b0) @(negedge clk);
      while (sclk_o !== 1'b1) @(negedge clk);
    end else begin
      sclk = 1'b1; fs = f;
      @(negedge clk);
      @(negedge clk);
      if (inj) begin di = ii; dq = qq; vld = 1'b1; end
      @(negedge clk);
      vld = 1'b0;
      @(negedge clk);
      sclk = 1'b0;
      @(negedge clk);
      @(negedge clk);
      @(negedge clk);
    end
    t_oe = sdo_oe; t_sdo = sdo; t_fs = fsync_o;
    if (!master) @(negedge clk);
  endtask

  task automatic mframe(input bit l, output logic [47:0] got, output bit fs_ok, output bit oe_ok);
    bit a, b, c;
    int guard = 0;
    got = '0; fs_ok = 1'b1; oe_ok = 1'b1;
    do begin
      tick(0, 0, 0, 0, a, b, c);
      guard++;
    end while (!c && guard < 200);
    if (a) oe_ok = 1'b0;
    for (int k = 0; k < (l ? 48 : 32); k++) begin
      tick(0, 0, 0, 0, a, b, c);
      got[47-k] = b;
      if (!a) oe_ok = 1'b0;
      if (k == 0 && c) fs_ok = 1'b0;
    end
  endtask

  task automatic sframe(input bit l, input bit lead, input int fs_at, input int inj_at,
                        input logic [23:0] xi, input logic [23:0] xq,
                        output logic [47:0] got, output bit oe_ok);
    bit a, b, c;
    got = '0; oe_ok = 1'b1;
    if (lead) begin
      tick(1, 0, 0, 0, a, b, c);
      if (a) oe_ok = 1'b0;
    end
    for (int k = 0; k < (l ? 48 : 32); k++) begin
      tick(k == fs_at, k == inj_at, xi, xq, a, b, c);
      got[47-k] = b;
      if (!a) oe_ok = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [47:0] got, exp;
    logic [23:0] pi, pq, xi, xq;
    bit fs_ok, oe_ok, a, b, c, l;
    int cnt;
    cnt = int'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    chk(!sdo && !sdo_oe && !sclk_o && !fsync_o, "R10 reset", {sdo, sdo_oe, sclk_o, fsync_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // master role
    master = 1'b1;
    repeat (4) @(negedge clk);
    chk(ctl_oe === 1'b1, "R5 ctl enable", ctl_oe, 1);
    while (sclk_o !== 1'b0) @(negedge clk);
    while (sclk_o !== 1'b1) @(negedge clk);
    cnt = 0;
    while (sclk_o !== 1'b0) begin @(negedge clk); cnt++; end
    while (sclk_o !== 1'b1) begin @(negedge clk); cnt++; end
    chk(cnt == DIV, "R5 sclk period", cnt, DIV);

    cnt = 0;
    for (int k = 0; k < 6; k++) begin
      tick(0, 0, 0, 0, a, b, c);
      if (a || c) cnt++;
    end
    chk(cnt == 0, "R7 idle no frame", cnt, 0);

    for (int n = 0; n < 6; n++) begin
      l = (n < 2) ? n[0] : 1'($urandom);
      w24 = l;
      pi = 24'($urandom); pq = 24'($urandom);
      if (n == 2) begin pi = 24'h800001; pq = 24'h000001; end
      push(pi, pq);
      mframe(l, got, fs_ok, oe_ok);
      exp = expf(pi, pq, l);
      chk(msk(got, l) == exp, "R1 R3 master frame data", got, exp);
      chk(fs_ok, "R6 fsync one period", fs_ok, 1);
      chk(oe_ok, "R2 enable span", oe_ok, 1);
      tick(0, 0, 0, 0, a, b, c);
      chk(!a && !b, "R2 release after Q LSB", {a, b}, 0);
    end

    w24 = 1'b0;
    push(24'h111111, 24'h222222);
    while (sdo_oe !== 1'b1) @(negedge clk);
    push(24'h333333, 24'h444444);
    push(24'h0A5A5A, 24'h05C3C3);
    while (sdo_oe !== 1'b0) @(negedge clk);
    mframe(0, got, fs_ok, oe_ok);
    exp = expf(24'h0A5A5A, 24'h05C3C3, 0);
    chk(msk(got, 0) == exp, "R8 newest held pair sent", got, exp);
    tick(0, 0, 0, 0, a, b, c);
    cnt = 0;
    for (int k = 0; k < 80; k++) begin
      tick(0, 0, 0, 0, a, b, c);
      if (a || c) cnt++;
    end
    chk(cnt == 0, "R7 single frame per pair", cnt, 0);

    // slave role
    rst_n = 1'b0; master = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    pi = 24'h5A5A5A; pq = 24'hA5A5A5;
    push(pi, pq);
    cnt = 0;
    for (int k = 0; k < 6; k++) begin
      tick(0, 0, 0, 0, a, b, c);
      if (a || b) cnt++;
    end
    chk(cnt == 0, "R4 silent without fsync", cnt, 0);
    chk(!sclk_o && !fsync_o && !ctl_oe, "R4 master pins idle", {sclk_o, fsync_o, ctl_oe}, 0);

    for (int n = 0; n < 4; n++) begin
      l = n[0];
      w24 = l;
      pi = 24'($urandom); pq = 24'($urandom);
      push(pi, pq);
      sframe(l, 1, -1, -1, 0, 0, got, oe_ok);
      exp = expf(pi, pq, l);
      chk(msk(got, l) == exp, "R1 R4 slave frame data", got, exp);
      chk(oe_ok, "R2 slave enable span", oe_ok, 1);
      tick(0, 0, 0, 0, a, b, c);
      chk(!a, "R2 slave release", a, 0);
    end

    w24 = 1'b0;
    pi = 24'h00C0DE; pq = 24'h00BEEF;
    push(pi, pq);
    sframe(0, 1, 5, -1, 0, 0, got, oe_ok);
    exp = expf(pi, pq, 0);
    chk(msk(got, 0) == exp, "R9 mid-frame fsync ignored data", got, exp);
    cnt = 0;
    for (int k = 0; k < 4; k++) begin
      tick(0, 0, 0, 0, a, b, c);
      if (a) cnt++;
    end
    chk(cnt == 0, "R9 no frame from ignored fsync", cnt, 0);

    sframe(0, 1, 31, -1, 0, 0, got, oe_ok);
    chk(msk(got, 0) == exp, "R9 first of back-to-back", got, exp);
    sframe(0, 0, -1, -1, 0, 0, got, oe_ok);
    chk(oe_ok && msk(got, 0) == exp, "R9 back-to-back repeat pair", got, exp);

    w24 = 1'b1;
    xi = 24'hFEDCBA; xq = 24'h123456;
    tick(0, 0, 0, 0, a, b, c);
    sframe(1, 1, -1, 0, xi, xq, got, oe_ok);
    exp = expf(pi, pq, 1);
    chk(got == exp, "R8 same-cycle pair not in running frame", got, exp);
    tick(0, 0, 0, 0, a, b, c);
    sframe(1, 1, -1, -1, 0, 0, got, oe_ok);
    exp = expf(xi, xq, 1);
    chk(got == exp, "R8 same-cycle pair in next frame", got, exp);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule